// File: doc/BRIEF.md
# I2C Address Buffer Steering Unit

This block sits between the byte shift register of an I2C controller and the ordinary transmit and receive data buffers. It holds two 8-bit address registers, called buffer 0 and buffer 1, and decides how address bytes move through them. In host operation it picks which byte goes into the shift register and in what order. For a 10-bit address it sends the second byte only after the client has acknowledged the first. In client operation it stores matched address bytes in the address registers, so they do not pass through the receive data buffer.

A disable input sends everything through a bypass path. Outgoing address bytes then come from the transmit data buffer, and received address bytes go to the receive data buffer. The byte order is the same as in buffered operation. The bit-level engine talks to this block through single-cycle strobes. Software loads the two registers through a simple write port, which is locked while a host address transfer is using them. A STOP or a bus reset returns the sequencers to idle and keeps the register contents.

Top module: `i2c_addr_steer`

## Requirements
- R1: After reset, both address registers read 0x00, and `busy`, `sr_load`, `txb_pop`, `rxb_wr`, `addr_done` and `addr_nack` are all 0.
- R2: Role encoding on `mode` is 00 host, 01 client, 10 seven-bit multi-host, 11 inactive. In host mode with `addr10`=0 and buffers enabled, a `hs_go` strobe in idle raises `sr_load` for exactly one cycle, starting one cycle later, with `sr_data` equal to buffer 1. A later `tx_done` with `tx_ack`=1 pulses `addr_done` in that same cycle and starts no second load.
- R3: In host mode with `addr10`=1, buffer 1 is loaded first. After a `tx_done` with `tx_ack`=1, the next cycle loads buffer 0. `addr_done` pulses on the ACK of that second byte.
- R4: If the first byte is not acknowledged (`tx_done`=1, `tx_ack`=0), `addr_nack` pulses in that cycle. No further byte is loaded, and `busy` is 0 from the next cycle on.
- R5: In client mode with `addr10`=0, a `rx_valid` with `rx_match`=1 writes `rx_data` into buffer 0 at the next edge, and buffer 1 is not changed. A byte with `rx_match`=0, or any received byte in host or inactive mode, changes neither register.
- R6: In client mode with `addr10`=1, the first matched byte goes to buffer 1. The next received byte goes to buffer 0 only if it matches. If it does not match, buffer 0 keeps its value.
- R7: In multi-host mode `addr10` is ignored. A host transfer sends only buffer 1, and a matched received byte goes to buffer 0.
- R8: With `buf_dis`=1, a host address byte is taken from `txb_data` with a one-cycle `txb_pop`, and received matched bytes appear on `rxb_data` with `rxb_wr`. Neither address register changes in this case.
- R9: `busy` is 1 while a host address sequence is active. While `busy`=1 and buffers are enabled, software writes to buffer 1 are ignored, and in 10-bit host mode writes to buffer 0 are ignored too.
- R10: `stop_det` returns both sequencers to idle at the next edge and keeps both registers. A `tx_done` that follows a STOP produces neither `addr_done` nor `addr_nack`.
- R11: Outside R9, a software write (`sw_wr_sel` 0 = buffer 0, 1 = buffer 1) stores `sw_wr_data` at the next edge. If a received byte captured by hardware targets the same register in the same cycle, the received byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Role: 00 host, 01 client, 10 multi-host, 11 inactive |
| addr10 | input | 1 | 10-bit addressing select |
| buf_dis | input | 1 | Address register bypass |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_sel | input | 1 | Software write target register |
| sw_wr_data | input | 8 | Software write data |
| hs_go | input | 1 | Start host address phase |
| tx_done | input | 1 | Shift register byte sent, ACK slot sampled |
| tx_ack | input | 1 | ACK value of that slot (1 = ACK) |
| txb_data | input | 8 | Head of the transmit data buffer |
| rx_valid | input | 1 | Address byte received |
| rx_match | input | 1 | Received byte matches own address |
| rx_data | input | 8 | Received byte |
| stop_det | input | 1 | STOP seen or bus reset |
| sr_load | output | 1 | Load strobe to the shift register |
| sr_data | output | 8 | Byte for the shift register |
| txb_pop | output | 1 | Consume the transmit data buffer head |
| rxb_wr | output | 1 | Write to the receive data buffer |
| rxb_data | output | 8 | Data for the receive data buffer |
| addr_buf0 | output | 8 | Buffer 0 contents |
| addr_buf1 | output | 8 | Buffer 1 contents |
| busy | output | 1 | Host address sequence active |
| addr_done | output | 1 | Address phase acknowledged |
| addr_nack | output | 1 | Address byte not acknowledged |

## Verification
The assertions assume the bit engine behaves well. `tx_done` arrives only after a load has been issued, and never in the same cycle as that load. `mode`, `addr10` and `buf_dis` do not change during a transfer. The stimulus follows these rules: it changes configuration only while the block is idle, and it raises `tx_done` only in the cycles after `sr_load` has dropped. Client bytes are applied only while no host sequence is running.

// File: rtl/i2c_adb_pkg.sv
package i2c_adb_pkg;
  localparam int unsigned ADB_W = 8;
  localparam int unsigned ADB_N = 2;

  typedef enum logic [1:0] {
    ROLE_HOST   = 2'b00,
    ROLE_CLIENT = 2'b01,
    ROLE_MULTI  = 2'b10,
    ROLE_OFF    = 2'b11
  } role_e;

  typedef enum logic [2:0] {
    HS_IDLE = 3'd0,
    HS_LD_HI = 3'd1,
    HS_W_HI = 3'd2,
    HS_LD_LO = 3'd3,
    HS_W_LO = 3'd4
  } hseq_e;

  typedef enum logic {
    CS_IDLE = 1'b0,
    CS_LO   = 1'b1
  } cseq_e;
endpackage

// File: rtl/i2c_adb_host_seq.sv
module i2c_adb_host_seq
  import i2c_adb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic two_byte,
  input  logic go,
  input  logic tx_done,
  input  logic tx_ack,
  input  logic stop,
  output logic load,
  output logic sel_lo,
  output logic active,
  output logic done,
  output logic nack
);
  hseq_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    done    = 1'b0;
    nack    = 1'b0;
    unique case (state_q)
      HS_IDLE:  if (go && en) state_d = HS_LD_HI;
      HS_LD_HI: state_d = HS_W_HI;
      HS_W_HI: begin
        if (tx_done) begin
          if (!tx_ack) begin
            nack    = 1'b1;
            state_d = HS_IDLE;
          end else if (two_byte) begin
            state_d = HS_LD_LO;
          end else begin
            done    = 1'b1;
            state_d = HS_IDLE;
          end
        end
      end
      HS_LD_LO: state_d = HS_W_LO;
      HS_W_LO: begin
        if (tx_done) begin
          done    = tx_ack;
          nack    = !tx_ack;
          state_d = HS_IDLE;
        end
      end
      default: state_d = HS_IDLE;
    endcase
    if (stop) begin
      state_d = HS_IDLE;
      done    = 1'b0;
      nack    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_IDLE;
    else        state_q <= state_d;
  end

  assign load   = (state_q == HS_LD_HI) || (state_q == HS_LD_LO);
  assign sel_lo = (state_q == HS_LD_LO) || (state_q == HS_W_LO);
  assign active = (state_q != HS_IDLE);
endmodule

// File: rtl/i2c_adb_client_cap.sv
module i2c_adb_client_cap
  import i2c_adb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic two_byte,
  input  logic rx_valid,
  input  logic rx_match,
  input  logic stop,
  output logic cap_hi,
  output logic cap_lo
);
  cseq_e state_q, state_d;
  logic  hit;

  assign hit    = en && rx_valid && rx_match && !stop;
  assign cap_hi = hit && two_byte && (state_q == CS_IDLE);
  assign cap_lo = hit && ((state_q == CS_LO) || !two_byte);

  always_comb begin
    state_d = state_q;
    if (stop || !en)                     state_d = CS_IDLE;
    else if (cap_hi)                     state_d = CS_LO;
    else if (state_q == CS_LO && rx_valid) state_d = CS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CS_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/i2c_adb_regs.sv
module i2c_adb_regs #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         hw_we,
  input  logic [W-1:0]         hw_data,
  input  logic                 sw_we,
  input  logic [$clog2(N)-1:0] sw_sel,
  input  logic [W-1:0]         sw_data,
  input  logic [N-1:0]         lock,
  output logic [N-1:0][W-1:0]  q
);
  for (genvar i = 0; i < N; i++) begin : g_buf
    logic         sw_hit;
    logic         en;
    logic [W-1:0] d;

    assign sw_hit = sw_we && (sw_sel == i) && !lock[i];
    assign en     = hw_we[i] || sw_hit;
    assign d      = hw_we[i] ? hw_data : sw_data;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= '0;
      else if (en) q[i] <= d;
    end
  end
endmodule

// File: rtl/i2c_addr_steer.sv
module i2c_addr_steer
  import i2c_adb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       addr10,
  input  logic       buf_dis,
  input  logic       sw_wr_en,
  input  logic       sw_wr_sel,
  input  logic [7:0] sw_wr_data,
  input  logic       hs_go,
  input  logic       tx_done,
  input  logic       tx_ack,
  input  logic [7:0] txb_data,
  input  logic       rx_valid,
  input  logic       rx_match,
  input  logic [7:0] rx_data,
  input  logic       stop_det,
  output logic       sr_load,
  output logic [7:0] sr_data,
  output logic       txb_pop,
  output logic       rxb_wr,
  output logic [7:0] rxb_data,
  output logic [7:0] addr_buf0,
  output logic [7:0] addr_buf1,
  output logic       busy,
  output logic       addr_done,
  output logic       addr_nack
);
  localparam int unsigned W = ADB_W;
  localparam int unsigned N = ADB_N;

  logic host_en, host_two, cli_en, cli_two;
  logic sel_lo, cap_hi, cap_lo;
  logic [N-1:0]        hw_we, lock;
  logic [N-1:0][W-1:0] bufs;

  assign host_en  = (mode == ROLE_HOST) || (mode == ROLE_MULTI);
  assign host_two = addr10 && (mode == ROLE_HOST);
  assign cli_en   = (mode == ROLE_CLIENT) || (mode == ROLE_MULTI);
  assign cli_two  = addr10 && (mode == ROLE_CLIENT);

  i2c_adb_host_seq u_host (
    .clk(clk), .rst_n(rst_n), .en(host_en), .two_byte(host_two),
    .go(hs_go), .tx_done(tx_done), .tx_ack(tx_ack), .stop(stop_det),
    .load(sr_load), .sel_lo(sel_lo), .active(busy),
    .done(addr_done), .nack(addr_nack)
  );

  i2c_adb_client_cap u_cli (
    .clk(clk), .rst_n(rst_n), .en(cli_en), .two_byte(cli_two),
    .rx_valid(rx_valid), .rx_match(rx_match), .stop(stop_det),
    .cap_hi(cap_hi), .cap_lo(cap_lo)
  );

  assign hw_we[0] = cap_lo && !buf_dis;
  assign hw_we[1] = cap_hi && !buf_dis;
  assign lock[1]  = busy && !buf_dis;
  assign lock[0]  = busy && !buf_dis && host_two;

  i2c_adb_regs #(.W(W), .N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .hw_we(hw_we), .hw_data(rx_data),
    .sw_we(sw_wr_en), .sw_sel(sw_wr_sel), .sw_data(sw_wr_data),
    .lock(lock), .q(bufs)
  );

  always_comb begin
    if (buf_dis)     sr_data = txb_data;
    else if (sel_lo) sr_data = bufs[0];
    else             sr_data = bufs[1];
  end

  assign txb_pop   = sr_load && buf_dis;
  assign rxb_wr    = (cap_hi || cap_lo) && buf_dis;
  assign rxb_data  = rx_data;
  assign addr_buf0 = bufs[0];
  assign addr_buf1 = bufs[1];
endmodule

// File: rtl/i2c_adb_chk.sv
module i2c_adb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       buf_dis,
  input logic       sw_wr_en,
  input logic       sw_wr_sel,
  input logic       stop_det,
  input logic       sr_load,
  input logic       busy,
  input logic       rxb_wr,
  input logic       addr_nack,
  input logic [7:0] addr_buf0,
  input logic [7:0] addr_buf1
);
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sr_load |=> !sr_load); // R2
  AST_LOAD_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    sr_load |-> busy); // R2
  AST_NACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    addr_nack |=> (!sr_load && !busy)); // R4
  AST_BYPASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_dis && !sw_wr_en) |=> ($stable(addr_buf0) && $stable(addr_buf1))); // R8
  AST_RXB_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    rxb_wr |-> buf_dis); // R8
  AST_LOCK_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !buf_dis && sw_wr_en && sw_wr_sel) |=> $stable(addr_buf1)); // R9
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !busy); // R10
endmodule

bind i2c_addr_steer i2c_adb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .buf_dis(buf_dis), .sw_wr_en(sw_wr_en),
  .sw_wr_sel(sw_wr_sel), .stop_det(stop_det), .sr_load(sr_load),
  .busy(busy), .rxb_wr(rxb_wr), .addr_nack(addr_nack),
  .addr_buf0(addr_buf0), .addr_buf1(addr_buf1)
);

// File: tb/i2c_addr_steer_test.sv
module i2c_addr_steer_test;
  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode;
  logic addr10, buf_dis, sw_wr_en, sw_wr_sel, hs_go, tx_done, tx_ack;
  logic rx_valid, rx_match, stop_det;
  logic [7:0] sw_wr_data, txb_data, rx_data;
  logic sr_load, txb_pop, rxb_wr, busy, addr_done, addr_nack;
  logic [7:0] sr_data, rxb_data, addr_buf0, addr_buf1;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  i2c_addr_steer uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr10(addr10), .buf_dis(buf_dis),
    .sw_wr_en(sw_wr_en), .sw_wr_sel(sw_wr_sel), .sw_wr_data(sw_wr_data),
    .hs_go(hs_go), .tx_done(tx_done), .tx_ack(tx_ack), .txb_data(txb_data),
    .rx_valid(rx_valid), .rx_match(rx_match), .rx_data(rx_data),
    .stop_det(stop_det), .sr_load(sr_load), .sr_data(sr_data),
    .txb_pop(txb_pop), .rxb_wr(rxb_wr), .rxb_data(rxb_data),
    .addr_buf0(addr_buf0), .addr_buf1(addr_buf1), .busy(busy),
    .addr_done(addr_done), .addr_nack(addr_nack)
  );

  // vector: mode[20:19] dis[18] match[17] data[16:9] exp_buf0[8:1] exp_rxb_wr[0]
  localparam int NV = 7;
  localparam logic [20:0] VEC [NV] = '{
    {2'b01, 1'b0, 1'b1, 8'hA4, 8'hA4, 1'b0},
    {2'b01, 1'b0, 1'b0, 8'h3C, 8'hA4, 1'b0},
    {2'b10, 1'b0, 1'b1, 8'h5B, 8'h5B, 1'b0},
    {2'b01, 1'b1, 1'b1, 8'h77, 8'h5B, 1'b1},
    {2'b10, 1'b1, 1'b1, 8'h12, 8'h5B, 1'b1},
    {2'b00, 1'b0, 1'b1, 8'h99, 8'h5B, 1'b0},
    {2'b01, 1'b0, 1'b1, 8'hC3, 8'hC3, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    sw_wr_en = 1'b1; sw_wr_sel = sel; sw_wr_data = d;
    @(posedge clk); #1;
    sw_wr_en = 1'b0;
  endtask

  task automatic go_host();
    @(negedge clk);
    hs_go = 1'b1;
    @(posedge clk); #1;
    hs_go = 1'b0;
  endtask

  // drives tx_done at the negedge after the current cycle, checks Mealy outputs
  task automatic ack_slot(input logic ack, input logic exp_done, input logic exp_nack, input string req);
    @(negedge clk);
    tx_done = 1'b1; tx_ack = ack;
    #1;
    check(req, addr_done, exp_done);
    check(req, addr_nack, exp_nack);
    @(posedge clk); #1;
    tx_done = 1'b0;
  endtask

  task automatic rx_byte(input logic m, input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_match = m; rx_data = d;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 2'b00; addr10 = 1'b0; buf_dis = 1'b0;
    sw_wr_en = 1'b0; sw_wr_sel = 1'b0; sw_wr_data = '0; hs_go = 1'b0;
    tx_done = 1'b0; tx_ack = 1'b0; txb_data = '0; rx_valid = 1'b0;
    rx_match = 1'b0; rx_data = '0; stop_det = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 buf0", addr_buf0, 8'h00);
    check("R1 buf1", addr_buf1, 8'h00);
    check("R1 outs", {busy, sr_load, txb_pop, rxb_wr, addr_done, addr_nack}, 6'b0);

    // client capture table (R5, R7, R8)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode = VEC[i][20:19]; buf_dis = VEC[i][18];
      rx_valid = 1'b1; rx_match = VEC[i][17]; rx_data = VEC[i][16:9];
      #1;
      check("R8 rxb_wr", rxb_wr, VEC[i][0]);
      if (VEC[i][0]) check("R8 rxb_data", rxb_data, VEC[i][16:9]);
      @(posedge clk); #1;
      rx_valid = 1'b0;
      check("R5 buf0", addr_buf0, VEC[i][8:1]);
      check("R5 buf1 kept", addr_buf1, 8'h00);
    end
    @(negedge clk); mode = 2'b00; buf_dis = 1'b0;

    // R11 software writes
    sw_write(1'b1, 8'hF1);
    sw_write(1'b0, 8'h0E);
    check("R11 buf1", addr_buf1, 8'hF1);
    check("R11 buf0", addr_buf0, 8'h0E);

    // R2 7-bit host
    go_host();
    check("R2 load", sr_load, 1'b1);
    check("R2 data", sr_data, 8'hF1);
    check("R9 busy", busy, 1'b1);
    @(posedge clk); #1;
    check("R2 one-cycle load", sr_load, 1'b0);
    ack_slot(1'b1, 1'b1, 1'b0, "R2 done");
    check("R2 no second load", sr_load, 1'b0);
    check("R2 idle", busy, 1'b0);

    // R3 10-bit host, with R9 locking on both registers
    @(negedge clk); addr10 = 1'b1;
    sw_write(1'b1, 8'hF6);
    sw_write(1'b0, 8'h34);
    go_host();
    check("R3 first", sr_data, 8'hF6);
    @(posedge clk); #1;
    sw_write(1'b1, 8'hAA);
    check("R9 buf1 locked", addr_buf1, 8'hF6);
    sw_write(1'b0, 8'hBB);
    check("R9 buf0 locked", addr_buf0, 8'h34);
    ack_slot(1'b1, 1'b0, 1'b0, "R3 first ack");
    check("R3 second load", sr_load, 1'b1);
    check("R3 second data", sr_data, 8'h34);
    @(posedge clk); #1;
    ack_slot(1'b1, 1'b1, 1'b0, "R3 done");
    check("R3 idle", busy, 1'b0);

    // R4 NACK on first 10-bit byte
    go_host();
    @(posedge clk); #1;
    ack_slot(1'b0, 1'b0, 1'b1, "R4 nack");
    check("R4 no buf0 load", sr_load, 1'b0);
    check("R4 idle", busy, 1'b0);

    // R10 STOP mid-sequence
    go_host();
    @(posedge clk); #1;
    @(negedge clk); stop_det = 1'b1;
    @(posedge clk); #1; stop_det = 1'b0;
    check("R10 idle", busy, 1'b0);
    check("R10 buf1 kept", addr_buf1, 8'hF6);
    ack_slot(1'b1, 1'b0, 1'b0, "R10 late tx_done");
    check("R10 no load", sr_load, 1'b0);

    // R9 write allowed once idle
    sw_write(1'b1, 8'hE2);
    check("R9 unlocked", addr_buf1, 8'hE2);

    // R7 multi-host ignores addr10
    @(negedge clk); mode = 2'b10;
    go_host();
    check("R7 data", sr_data, 8'hE2);
    @(posedge clk); #1;
    ack_slot(1'b1, 1'b1, 1'b0, "R7 single byte");
    check("R7 no second", sr_load, 1'b0);

    // R8 host bypass
    @(negedge clk); mode = 2'b00; addr10 = 1'b0; buf_dis = 1'b1; txb_data = 8'h3D;
    go_host();
    check("R8 txb data", sr_data, 8'h3D);
    check("R8 pop", txb_pop, 1'b1);
    @(posedge clk); #1;
    ack_slot(1'b1, 1'b1, 1'b0, "R8 done");
    check("R8 buf1 kept", addr_buf1, 8'hE2);

    // R6 10-bit client
    @(negedge clk); mode = 2'b01; addr10 = 1'b1; buf_dis = 1'b0;
    rx_byte(1'b1, 8'hF0);
    check("R6 upper", addr_buf1, 8'hF0);
    rx_byte(1'b1, 8'h5A);
    check("R6 lower", addr_buf0, 8'h5A);
    rx_byte(1'b1, 8'hF2);
    check("R6 upper2", addr_buf1, 8'hF2);
    rx_byte(1'b0, 8'h66);
    check("R6 mismatch keeps", addr_buf0, 8'h5A);

    // R11 collision: hardware capture wins
    @(negedge clk); addr10 = 1'b0;
    sw_wr_en = 1'b1; sw_wr_sel = 1'b0; sw_wr_data = 8'h11;
    rx_valid = 1'b1; rx_match = 1'b1; rx_data = 8'h9C;
    @(posedge clk); #1;
    sw_wr_en = 1'b0; rx_valid = 1'b0;
    check("R11 hw wins", addr_buf0, 8'h9C);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule